// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This combinational control unit sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares register numbers across the stages. From those comparisons it produces three kinds of control. The first selects where each ALU operand in the execute stage comes from. The second freezes the front of the pipeline and puts a bubble into execute while decode waits for a value. The third discards the younger instructions when a branch resolved in the memory stage turns out to be taken.

A single mode input chooses between two operating styles. With bypassing on, a result is passed straight from the memory-stage or writeback-stage pipeline register to the ALU, and ALU-to-ALU dependences never stall. With bypassing off, the unit acts as a pure interlock. A dependent instruction is held in decode until its producer reaches writeback. The register file writes in the first half of the writeback cycle and is read in the second half, so the value is available in that cycle. A producer directly ahead of the consumer therefore costs two stall cycles, and a producer two instructions ahead costs one.

Branches are predicted not taken. A taken branch discards the instructions in fetch, decode and execute. Discarding takes precedence over any stall request in the same cycle.

Top module: `hazard_ctl`

## Requirements
- R1: With `fwd_mode`=1, an execute-stage source equal to the destination of a qualifying memory-stage producer yields operand select 2'b10 (take the memory-stage result).
- R2: With `fwd_mode`=1, an execute-stage source that matches only a qualifying writeback-stage producer yields operand select 2'b01. With no match the select is 2'b00 (register file).
- R3: When both the memory-stage and the writeback-stage producers qualify and match the same source, the select is 2'b10, because the memory-stage value is the newer one.
- R4: A producer qualifies only if its valid and write-enable bits are both 1 and its destination is not register 0. A non-qualifying producer never causes a bypass or a stall.
- R5: With `fwd_mode`=0, both operand selects are always 2'b00.
- R6: With `fwd_mode`=0, `stall` is 1 while a decode-stage source matches a qualifying execute-stage producer. Followed through the pipeline, a producer directly ahead of its consumer gives exactly two stall cycles.
- R7: With `fwd_mode`=0, `stall` is 1 while a decode-stage source matches a qualifying memory-stage producer, and 0 when the only match is in writeback. A producer two instructions ahead gives exactly one stall cycle.
- R8: With `fwd_mode`=1, `stall` is never asserted.
- R9: `mem_br_taken`=1 drives `flush_if`, `flush_id` and `flush_ex` all to 1. Otherwise all three are 0.
- R10: While `mem_br_taken`=1, `stall` is 0 even if an interlock condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 1 = bypass results to the ALU, 0 = interlock only |
| id_src_a | input | 5 | First source register of the decode-stage instruction (0 if unused) |
| id_src_b | input | 5 | Second source register of the decode-stage instruction (0 if unused) |
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| ex_vld | input | 1 | Execute stage holds a real instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination register |
| mem_vld | input | 1 | Memory stage holds a real instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| wb_vld | input | 1 | Writeback stage holds a real instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | 5 | Writeback-stage destination register |
| mem_br_taken | input | 1 | Branch in the memory stage resolved taken |
| opa_sel | output | 2 | ALU operand A source: 00 register file, 01 writeback, 10 memory stage |
| opb_sel | output | 2 | ALU operand B source, same encoding |
| stall | output | 1 | Hold PC and the fetch/decode register, bubble into execute |
| flush_if | output | 1 | Discard the fetch-stage instruction |
| flush_id | output | 1 | Discard the decode-stage instruction |
| flush_ex | output | 1 | Discard the execute-stage instruction |

## Verification
The bench aims at the bypass priority case, where both later stages write the register being read. A unit that ranked them the wrong way round would feed the ALU a stale value. It checks register 0 as a destination, and producers that are cleared by a missing valid or write-enable bit. A unit that ignored either qualifier would stall or bypass on bubbles and non-writing instructions. It follows a producer through execute, memory and writeback in interlock mode and counts the stall cycles. An off-by-one stage comparison would show up as one or three stalls where two are expected, or as a stall in the writeback cycle. A taken branch is applied together with a live interlock. A unit without flush precedence would freeze the wrong-path instructions rather than discard them.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W  = 5;
    localparam int N_OPND = 2;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic vld;
        logic we;
        reg_t dst;
    } prod_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } opsel_e;

    // A producer is live only when it is real, writes, and does not target r0.
    function automatic logic prod_live(prod_t p);
        return p.vld && p.we && (p.dst != '0);
    endfunction

    function automatic logic prod_hits(prod_t p, reg_t src);
        return prod_live(p) && (p.dst == src);
    endfunction

endpackage

// File: rtl/hz_opsel.sv
module hz_opsel
    import hz_pkg::*;
(
    input  logic   fwd_en,
    input  reg_t   src,
    input  prod_t  p_mem,
    input  prod_t  p_wb,
    output opsel_e sel
);

    logic hit_mem;
    logic hit_wb;

    assign hit_mem = prod_hits(p_mem, src);
    assign hit_wb  = prod_hits(p_wb, src);

    // Newer result (memory stage) wins over the older one (writeback).
    always_comb begin
        sel = SEL_RF;
        if (fwd_en) begin
            if (hit_mem)     sel = SEL_MEM;
            else if (hit_wb) sel = SEL_WB;
        end
    end

    always_comb begin
        if (!fwd_en) begin
            p_no_bypass_off_r5: assert (sel == SEL_RF);
        end
        if (src == '0) begin
            p_zero_src_rf_r4: assert (sel == SEL_RF);
        end
        if (fwd_en && p_mem.vld && p_mem.we && p_mem.dst == src && src != '0) begin
            p_mem_first_r3: assert (sel == SEL_MEM);
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
(
    input  logic  ilk_en,
    input  reg_t  src_a,
    input  reg_t  src_b,
    input  prod_t p_ex,
    input  prod_t p_mem,
    output logic  hold
);

    logic [N_OPND-1:0] dep;
    reg_t              srcs [N_OPND];

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    // Writeback is not compared: the register file is written before it is read.
    for (genvar g = 0; g < N_OPND; g++) begin : g_dep
        assign dep[g] = prod_hits(p_ex, srcs[g]) || prod_hits(p_mem, srcs[g]);
    end

    assign hold = ilk_en && (|dep);

    always_comb begin
        if (!ilk_en) begin
            p_no_hold_fwd_r8: assert (!hold);
        end
        if (!p_ex.vld && !p_mem.vld) begin
            p_idle_no_hold_r4: assert (!hold);
        end
    end

endmodule

// File: rtl/hz_flush.sv
module hz_flush (
    input  logic br_taken,
    input  logic hold_req,
    output logic stall,
    output logic flush_if,
    output logic flush_id,
    output logic flush_ex
);

    assign flush_if = br_taken;
    assign flush_id = br_taken;
    assign flush_ex = br_taken;
    assign stall    = hold_req && !br_taken;

    always_comb begin
        p_flush_group_r9: assert ($countones({flush_if, flush_id, flush_ex}) == 0 ||
                                  $countones({flush_if, flush_id, flush_ex}) == 3);
        if (flush_ex) begin
            p_flush_beats_stall_r10: assert (!stall);
        end
    end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hz_pkg::*;
(
    input  logic             fwd_mode,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             ex_vld,
    input  logic             ex_we,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_vld,
    input  logic             mem_we,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_vld,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             mem_br_taken,
    output logic [1:0]       opa_sel,
    output logic [1:0]       opb_sel,
    output logic             stall,
    output logic             flush_if,
    output logic             flush_id,
    output logic             flush_ex
);

    prod_t  p_ex;
    prod_t  p_mem;
    prod_t  p_wb;
    reg_t   ex_src [N_OPND];
    opsel_e sel    [N_OPND];
    logic   hold;

    assign p_ex  = '{vld: ex_vld,  we: ex_we,  dst: ex_dst};
    assign p_mem = '{vld: mem_vld, we: mem_we, dst: mem_dst};
    assign p_wb  = '{vld: wb_vld,  we: wb_we,  dst: wb_dst};

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_opsel u_opsel (
            .fwd_en (fwd_mode),
            .src    (ex_src[g]),
            .p_mem  (p_mem),
            .p_wb   (p_wb),
            .sel    (sel[g])
        );
    end

    assign opa_sel = sel[0];
    assign opb_sel = sel[1];

    hz_interlock u_ilk (
        .ilk_en (!fwd_mode),
        .src_a  (id_src_a),
        .src_b  (id_src_b),
        .p_ex   (p_ex),
        .p_mem  (p_mem),
        .hold   (hold)
    );

    hz_flush u_flush (
        .br_taken (mem_br_taken),
        .hold_req (hold),
        .stall    (stall),
        .flush_if (flush_if),
        .flush_id (flush_id),
        .flush_ex (flush_ex)
    );

    always_comb begin
        if (fwd_mode) begin
            p_fwd_never_stall_r8: assert (!stall);
        end
        if (mem_br_taken) begin
            p_taken_no_stall_r10: assert (!stall && flush_if);
        end
    end

endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fwd_mode = 1'b1;
    logic [4:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
    logic       ex_vld = 0, ex_we = 0, mem_vld = 0, mem_we = 0, wb_vld = 0, wb_we = 0;
    logic [4:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic       mem_br_taken = 0;
    logic [1:0] opa_sel, opb_sel;
    logic       stall, flush_if, flush_id, flush_ex;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hazard_ctl u0 (
        .fwd_mode(fwd_mode), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_vld(ex_vld), .ex_we(ex_we), .ex_dst(ex_dst),
        .mem_vld(mem_vld), .mem_we(mem_we), .mem_dst(mem_dst),
        .wb_vld(wb_vld), .wb_we(wb_we), .wb_dst(wb_dst),
        .mem_br_taken(mem_br_taken),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .stall(stall),
        .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_all();
        id_src_a = '0; id_src_b = '0; ex_src_a = '0; ex_src_b = '0;
        ex_vld = 0; ex_we = 0; ex_dst = '0;
        mem_vld = 0; mem_we = 0; mem_dst = '0;
        wb_vld = 0; wb_we = 0; wb_dst = '0;
        mem_br_taken = 0;
    endtask

    // Drive on the falling edge, sample a little later.
    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset_state();
        clear_all(); fwd_mode = 1;
        settle();
        chk("R2 idle opa", opa_sel, 0);
        chk("R2 idle opb", opb_sel, 0);
        chk("R9 idle flush", {flush_if, flush_id, flush_ex}, 0);
        chk("R8 idle stall", stall, 0);
    endtask

    task automatic t_fwd_mem();
        clear_all(); fwd_mode = 1;
        ex_src_a = 5'd9; ex_src_b = 5'd3;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd9;
        settle();
        chk("R1 opa from mem", opa_sel, 2);
        chk("R1 opb untouched", opb_sel, 0);
        ex_src_a = 5'd4; ex_src_b = 5'd9;
        settle();
        chk("R1 opb from mem", opb_sel, 2);
        chk("R1 opa untouched", opa_sel, 0);
    endtask

    task automatic t_fwd_wb();
        clear_all(); fwd_mode = 1;
        ex_src_a = 5'd17; ex_src_b = 5'd17;
        wb_vld = 1; wb_we = 1; wb_dst = 5'd17;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd8;
        settle();
        chk("R2 opa from wb", opa_sel, 1);
        chk("R2 opb from wb", opb_sel, 1);
    endtask

    task automatic t_priority();
        clear_all(); fwd_mode = 1;
        ex_src_a = 5'd12; ex_src_b = 5'd12;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd12;
        wb_vld = 1;  wb_we = 1;  wb_dst = 5'd12;
        settle();
        chk("R3 newer wins a", opa_sel, 2);
        chk("R3 newer wins b", opb_sel, 2);
    endtask

    task automatic t_qualify();
        clear_all(); fwd_mode = 1;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd0;
        wb_vld = 1;  wb_we = 1;  wb_dst = 5'd0;
        settle();
        chk("R4 r0 never bypassed", opa_sel, 0);
        ex_src_a = 5'd6; mem_dst = 5'd6; mem_we = 0;
        settle();
        chk("R4 no write enable", opa_sel, 0);
        mem_we = 1; mem_vld = 0;
        settle();
        chk("R4 invalid producer", opa_sel, 0);
        fwd_mode = 0; id_src_a = 5'd0; ex_vld = 1; ex_we = 1; ex_dst = 5'd0;
        settle();
        chk("R4 r0 never stalls", stall, 0);
        id_src_a = 5'd7; ex_dst = 5'd7; ex_we = 0;
        settle();
        chk("R4 no-write producer no stall", stall, 0);
        ex_we = 1; ex_vld = 0;
        settle();
        chk("R4 bubble no stall", stall, 0);
    endtask

    task automatic t_interlock_sel();
        clear_all(); fwd_mode = 0;
        ex_src_a = 5'd5; ex_src_b = 5'd5;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd5;
        wb_vld = 1;  wb_we = 1;  wb_dst = 5'd5;
        settle();
        chk("R5 interlock opa", opa_sel, 0);
        chk("R5 interlock opb", opb_sel, 0);
    endtask

    // Producer directly ahead: visible in EX, then MEM, then WB.
    task automatic t_two_stall();
        int cnt = 0;
        clear_all(); fwd_mode = 0;
        id_src_b = 5'd20;
        ex_vld = 1; ex_we = 1; ex_dst = 5'd20;
        settle(); chk("R6 stall producer in ex", stall, 1); cnt += int'(stall);
        clear_all(); id_src_b = 5'd20;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd20;
        settle(); cnt += int'(stall);
        clear_all(); id_src_b = 5'd20;
        wb_vld = 1; wb_we = 1; wb_dst = 5'd20;
        settle(); cnt += int'(stall);
        chk("R6 two stall cycles", cnt, 2);
    endtask

    task automatic t_one_stall();
        int cnt = 0;
        clear_all(); fwd_mode = 0;
        id_src_a = 5'd11;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd11;
        settle(); chk("R7 stall producer in mem", stall, 1); cnt += int'(stall);
        clear_all(); id_src_a = 5'd11;
        wb_vld = 1; wb_we = 1; wb_dst = 5'd11;
        settle(); chk("R7 no stall producer in wb", stall, 0); cnt += int'(stall);
        chk("R7 one stall cycle", cnt, 1);
    endtask

    task automatic t_fwd_no_stall();
        clear_all(); fwd_mode = 1;
        id_src_a = 5'd2; id_src_b = 5'd3;
        ex_vld = 1; ex_we = 1; ex_dst = 5'd2;
        mem_vld = 1; mem_we = 1; mem_dst = 5'd3;
        settle();
        chk("R8 bypass mode no stall", stall, 0);
    endtask

    task automatic t_branch();
        clear_all(); fwd_mode = 1; mem_br_taken = 1;
        settle();
        chk("R9 flush group", {flush_if, flush_id, flush_ex}, 7);
        mem_br_taken = 0;
        settle();
        chk("R9 flush released", {flush_if, flush_id, flush_ex}, 0);
    endtask

    task automatic t_flush_over_stall();
        clear_all(); fwd_mode = 0;
        id_src_a = 5'd14; ex_vld = 1; ex_we = 1; ex_dst = 5'd14;
        mem_br_taken = 1;
        settle();
        chk("R10 stall suppressed", stall, 0);
        chk("R10 flush kept", {flush_if, flush_id, flush_ex}, 7);
        mem_br_taken = 0;
        settle();
        chk("R10 stall returns", stall, 1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 0;
        t_reset_state();
        t_fwd_mem();
        t_fwd_wb();
        t_priority();
        t_qualify();
        t_interlock_sel();
        t_two_stall();
        t_one_stall();
        t_fwd_no_stall();
        t_branch();
        t_flush_over_stall();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule